// File: doc/BRIEF.md
# Steered Serial Control and Audio Port

This block is the slave side of a synchronous serial link. An external bit clock drives it, and a one-bit-wide start pulse marks each sample frame. In every frame one word arrives on the serial input line and one word leaves on the serial output line. The output is enabled only while its word bits are on the wire.

In 16-bit framing, the first bit received decides what the word is. A zero makes it an audio sample. A one makes it an access to a small file of three 12-bit configuration registers:
- The second bit selects read (1) or write (0).
- The next two bits select the register.
- The low twelve bits are the payload.

A write returns the register's previous contents. A read returns the current contents. In a frame that carries a control word, the audio sample held toward the processing core is left unchanged. Two register bits act as a soft reset and a sleep request. The register that holds them is protected by an unlock word.

An 8-bit companded framing is also available. In that framing there is no steering and no register access.

Top module: `ssp_port`

## Requirements
- R1: While `rst_ni` is low, all three registers, `rx_audio_o`, `sdo_oe_o` and the pending response word are cleared. This also clears the soft-reset bit.
- R2: A `sync_i` high sampled at a rising edge starts a frame. `sdo_oe_o` is then high for exactly the word length: 16 cycles when `wide_i`=1, 8 cycles when `wide_i`=0. It starts in the cycle after that edge, is low otherwise, and output bits go out MSB first.
- R3: In 16-bit linear framing (`wide_i`=1, `comp_i`=0), a word whose bit 15 is 0 is audio. At the end of the frame, `rx_audio_o` becomes `{word[14:0],1'b0}` and `frame_o` pulses for one cycle. The next frame transmits `tx_audio_i` as sampled at that frame end.
- R4: A control word has bit 15 = 1, bit 14 = read flag (1 = read), and bits 13:12 = register select (00 = CR0, 01 = CR1, 10 = CR2, 11 = reserved). A write (bit 14 = 0) to CR1 or CR2 stores bits 11:0. The next frame transmits `{1, rd, sel, value before the write}`.
- R5: A read leaves the register unchanged, whatever its payload. The next frame transmits `{1, 1, sel, current value}`.
- R6: A control frame leaves `rx_audio_o` at the previous sample and transmits no audio in the following frame.
- R7: A CR0 write takes effect only in two cases: the whole word equals 0x8400, or the control word received in the frame just before was 0x8400. Any other frame in between removes that permission.
- R8: CR0 bit 11 is the soft reset (`soft_rst_o`) and CR0 bit 10 is sleep (`sleep_o`). While bit 11 is set, writes to CR1 and CR2 are ignored, and a permitted CR0 write changes only bit 11.
- R9: In 16-bit companded framing (`wide_i`=1, `comp_i`=1), an audio word is eight zeros followed by data: `rx_audio_o` becomes `{8'h00, word[7:0]}`. The transmitted audio is `{tx_audio_i[7:0], 8'h00}`.
- R10: In 8-bit framing (`wide_i`=0), every frame is audio, even with bit 7 set: `rx_audio_o` becomes `{8'h00, byte}`, the transmitted byte is `tx_audio_i[7:0]`, and no register changes.
- R11: Register select 11 is reserved. A write to it changes nothing, and its read-back payload is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial bit clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| sync_i | input | 1 | Start-of-frame pulse, one cycle before the first bit |
| sdi_i | input | 1 | Serial data in, MSB first |
| wide_i | input | 1 | 1 = 16-bit framing, 0 = 8-bit companded framing |
| comp_i | input | 1 | 1 = companded audio inside 16-bit framing |
| tx_audio_i | input | 16 | Audio sample from the core toward the serial line |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for sdo_o (high-impedance when low) |
| rx_audio_o | output | 16 | Last received audio sample |
| frame_o | output | 1 | One-cycle pulse at the end of every frame |
| cr0_o | output | 12 | Register CR0 |
| cr1_o | output | 12 | Register CR1 |
| cr2_o | output | 12 | Register CR2 |
| soft_rst_o | output | 1 | Soft-reset bit |
| sleep_o | output | 1 | Sleep bit |

## Verification
Call the edge that samples `sync_i` edge t. The first output bit is valid after edge t, and the last input bit is captured at edge t+N, where N is 16 or 8. At that edge the registers, `rx_audio_o` and `frame_o` all change together, so they are checked in the half cycle right after it. The response to a word appears only in the serial bits of the following frame. The bench drives and samples on falling edges only. It captures one output bit per falling edge from the one after edge t, checks the results one falling edge after the last bit, and leaves idle cycles between frames.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int unsigned PAY_W   = 12;
  localparam int unsigned NREG    = 3;
  localparam int unsigned SRST_B  = 11;
  localparam int unsigned SLEEP_B = 10;
  localparam logic [15:0] UNLOCK_WORD = 16'h8400;

  typedef enum logic [1:0] {
    SEL_CR0 = 2'd0,
    SEL_CR1 = 2'd1,
    SEL_CR2 = 2'd2,
    SEL_RSV = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic             steer;
    logic             rd;
    reg_sel_e         sel;
    logic [PAY_W-1:0] pay;
  } ctl_word_t;
endpackage

// File: rtl/ssp_shift.sv
module ssp_shift #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NARROW_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_i,
  input  logic              sdi_i,
  input  logic              wide_i,
  input  logic [DATA_W-1:0] resp_i,
  output logic              sdo_o,
  output logic              oe_o,
  output logic              done_o,
  output logic [DATA_W-1:0] word_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q, last_c;
  logic [DATA_W-1:0] rx_sr_q, tx_sr_q;

  assign last_c = wide_i ? CNT_W'(DATA_W-1) : CNT_W'(NARROW_W-1);
  assign done_o = busy_q && !sync_i && (cnt_q == last_c);
  assign word_o = {rx_sr_q[DATA_W-2:0], sdi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      rx_sr_q <= '0;
      tx_sr_q <= '0;
      sdo_o   <= 1'b0;
      oe_o    <= 1'b0;
    end else if (sync_i) begin
      // first output bit valid the cycle after sync, input bits follow
      busy_q  <= 1'b1;
      cnt_q   <= '0;
      tx_sr_q <= resp_i << 1;
      sdo_o   <= resp_i[DATA_W-1];
      oe_o    <= 1'b1;
    end else if (busy_q) begin
      rx_sr_q <= word_o;
      cnt_q   <= cnt_q + 1'b1;
      if (cnt_q == last_c) begin
        busy_q <= 1'b0;
        oe_o   <= 1'b0;
        sdo_o  <= 1'b0;
      end else begin
        sdo_o   <= tx_sr_q[DATA_W-1];
        tx_sr_q <= tx_sr_q << 1;
      end
    end
  end
endmodule

// File: rtl/ssp_regs.sv
module ssp_regs
  import ssp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_i,
  input  logic             ctl_i,
  input  ctl_word_t        word_i,
  output logic [PAY_W-1:0] cr0_o,
  output logic [PAY_W-1:0] cr1_o,
  output logic [PAY_W-1:0] cr2_o,
  output logic [PAY_W-1:0] rd_val_o
);
  logic [PAY_W-1:0] cr_q [NREG];
  logic [NREG-1:0]  we;
  logic [PAY_W-1:0] wmask [NREG];
  logic             armed_q, in_rst, is_key, wr;

  assign in_rst = cr_q[0][SRST_B];
  assign is_key = (word_i == ctl_word_t'(UNLOCK_WORD));
  assign wr     = done_i && ctl_i && !word_i.rd;

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      we[i]    = 1'b0;
      wmask[i] = '1;
    end
    if (wr) begin
      unique case (word_i.sel)
        SEL_CR0: begin
          we[0] = is_key || armed_q;
          wmask[0] = in_rst ? PAY_W'(1) << SRST_B : '1;
        end
        SEL_CR1: we[1] = !in_rst;
        SEL_CR2: we[2] = !in_rst;
        default: ;
      endcase
    end
  end

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    cr_q[g] <= '0;
        else if (we[g]) cr_q[g] <= (cr_q[g] & ~wmask[g]) | (word_i.pay & wmask[g]);
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     armed_q <= 1'b0;
    else if (done_i) armed_q <= ctl_i && is_key;
  end

  always_comb begin
    unique case (word_i.sel)
      SEL_CR0: rd_val_o = cr_q[0];
      SEL_CR1: rd_val_o = cr_q[1];
      SEL_CR2: rd_val_o = cr_q[2];
      default: rd_val_o = '0;
    endcase
  end

  assign cr0_o = cr_q[0];
  assign cr1_o = cr_q[1];
  assign cr2_o = cr_q[2];
endmodule

// File: rtl/ssp_port.sv
module ssp_port
  import ssp_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NARROW_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_i,
  input  logic              sdi_i,
  input  logic              wide_i,
  input  logic              comp_i,
  input  logic [DATA_W-1:0] tx_audio_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [DATA_W-1:0] rx_audio_o,
  output logic              frame_o,
  output logic [PAY_W-1:0]  cr0_o,
  output logic [PAY_W-1:0]  cr1_o,
  output logic [PAY_W-1:0]  cr2_o,
  output logic              soft_rst_o,
  output logic              sleep_o
);
  localparam int unsigned PAD_W = DATA_W - NARROW_W;

  logic              done, is_ctl, narrow;
  logic [DATA_W-1:0] word, resp_q;
  logic [PAY_W-1:0]  rd_val;
  ctl_word_t         cw;

  assign cw     = ctl_word_t'(word);
  assign is_ctl = wide_i && cw.steer;
  assign narrow = !wide_i || comp_i;

  ssp_shift #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i (sync_i),
    .sdi_i  (sdi_i),
    .wide_i (wide_i),
    .resp_i (resp_q),
    .sdo_o  (sdo_o),
    .oe_o   (sdo_oe_o),
    .done_o (done),
    .word_o (word)
  );

  ssp_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .done_i   (done),
    .ctl_i    (is_ctl),
    .word_i   (cw),
    .cr0_o    (cr0_o),
    .cr1_o    (cr1_o),
    .cr2_o    (cr2_o),
    .rd_val_o (rd_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_q     <= '0;
      rx_audio_o <= '0;
      frame_o    <= 1'b0;
    end else begin
      frame_o <= done;
      if (done) begin
        if (is_ctl) begin
          resp_q <= {1'b1, cw.rd, cw.sel, rd_val};
        end else if (narrow) begin
          resp_q     <= {tx_audio_i[NARROW_W-1:0], {PAD_W{1'b0}}};
          rx_audio_o <= {{PAD_W{1'b0}}, word[NARROW_W-1:0]};
        end else begin
          resp_q     <= tx_audio_i;
          rx_audio_o <= {word[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  assign soft_rst_o = cr0_o[SRST_B];
  assign sleep_o    = cr0_o[SLEEP_B];
endmodule

// File: rtl/ssp_port_chk.sv
module ssp_port_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned PAY_W  = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sync_i,
  input logic              wide_i,
  input logic              sdo_oe_o,
  input logic              frame_o,
  input logic [DATA_W-1:0] rx_audio_o,
  input logic [PAY_W-1:0]  cr0_o,
  input logic [PAY_W-1:0]  cr1_o,
  input logic [PAY_W-1:0]  cr2_o
);
  assert_oe_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdo_oe_o) |-> $past(sync_i));

  assert_frame_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |=> !frame_o);

  assert_audio_update_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rx_audio_o) |-> frame_o);

  assert_cr0_at_frame_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cr0_o) |-> frame_o);

  assert_rst_freeze_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cr0_o[11]) |-> ($stable(cr1_o) && $stable(cr2_o) && $stable(cr0_o[10:0])));

  assert_narrow_no_ctl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wide_i |-> ($stable(cr0_o) && $stable(cr1_o) && $stable(cr2_o)));
endmodule

bind ssp_port ssp_port_chk #(.DATA_W(DATA_W), .PAY_W(ssp_pkg::PAY_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sync_i     (sync_i),
  .wide_i     (wide_i),
  .sdo_oe_o   (sdo_oe_o),
  .frame_o    (frame_o),
  .rx_audio_o (rx_audio_o),
  .cr0_o      (cr0_o),
  .cr1_o      (cr1_o),
  .cr2_o      (cr2_o)
);

// File: tb/ssp_port_test.sv
module ssp_port_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sync_i = 1'b0, sdi_i = 1'b0, wide_i = 1'b1, comp_i = 1'b0;
  logic [15:0] tx_audio_i = '0;
  logic        sdo_o, sdo_oe_o, frame_o, soft_rst_o, sleep_o;
  logic [15:0] rx_audio_o;
  logic [11:0] cr0_o, cr1_o, cr2_o;
  int          total = 0, bad = 0;
  logic [15:0] got;

  always #4 clk = ~clk;

  ssp_port uut (
    .clk_i(clk), .rst_ni(rst_ni), .sync_i(sync_i), .sdi_i(sdi_i),
    .wide_i(wide_i), .comp_i(comp_i), .tx_audio_i(tx_audio_i),
    .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .rx_audio_o(rx_audio_o),
    .frame_o(frame_o), .cr0_o(cr0_o), .cr1_o(cr1_o), .cr2_o(cr2_o),
    .soft_rst_o(soft_rst_o), .sleep_o(sleep_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [15:0] w, input int n, output logic [15:0] q);
    int oe_cnt = 0;
    q = '0;
    @(negedge clk);
    chk("R2 oe low before frame", 32'(sdo_oe_o), 0);
    sync_i = 1'b1;
    @(negedge clk);
    sync_i = 1'b0;
    for (int k = 0; k < n; k++) begin
      if (k > 0) @(negedge clk);
      q = {q[14:0], sdo_o};
      oe_cnt += int'(sdo_oe_o);
      sdi_i = w[n-1-k];
    end
    @(negedge clk);
    sdi_i = 1'b0;
    chk("R2 oe width", 32'(oe_cnt), 32'(n));
    chk("R2 oe low after frame", 32'(sdo_oe_o), 0);
    chk("R3 frame pulse", 32'(frame_o), 1);
    @(negedge clk);
    chk("R2 frame pulse width", 32'(frame_o), 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 cr0", 32'(cr0_o), 0);
    chk("R1 cr1", 32'(cr1_o), 0);
    chk("R1 cr2", 32'(cr2_o), 0);
    chk("R1 soft reset", 32'(soft_rst_o), 0);
    chk("R1 rx audio", 32'(rx_audio_o), 0);
    chk("R1 oe", 32'(sdo_oe_o), 0);
    rst_ni = 1'b1;
  endtask

  task automatic t_audio();
    tx_audio_i = 16'hA5C3;
    frame(16'h1234, 16, got);
    chk("R1 first response zero", 32'(got), 0);
    chk("R3 rx audio", 32'(rx_audio_o), 32'h2468);
    tx_audio_i = 16'h5A3C;
    frame(16'h7FFF, 16, got);
    chk("R3 tx audio next frame", 32'(got), 32'hA5C3);
    chk("R3 rx audio full", 32'(rx_audio_o), 32'hFFFE);
  endtask

  task automatic t_regs();
    frame(16'h9ABC, 16, got);
    chk("R3 tx audio", 32'(got), 32'h5A3C);
    chk("R4 cr1 write", 32'(cr1_o), 32'hABC);
    chk("R6 rx audio held", 32'(rx_audio_o), 32'hFFFE);
    frame(16'h9123, 16, got);
    chk("R4 write readback old", 32'(got), 32'h9000);
    chk("R4 cr1 second write", 32'(cr1_o), 32'h123);
    frame(16'hD555, 16, got);
    chk("R4 readback old of back-to-back", 32'(got), 32'h9ABC);
    chk("R5 read leaves reg", 32'(cr1_o), 32'h123);
    frame(16'h2222, 16, got);
    chk("R5 read returns current", 32'(got), 32'hD123);
    chk("R6 no audio in ctl response", 32'(got), 32'hD123);
    chk("R3 rx audio", 32'(rx_audio_o), 32'h4444);
    frame(16'hA0F0, 16, got);
    chk("R4 cr2 write", 32'(cr2_o), 32'h0F0);
  endtask

  task automatic t_cr0();
    frame(16'h8C00, 16, got);
    chk("R4 cr2 readback", 32'(got), 32'hA000);
    chk("R7 cr0 locked", 32'(cr0_o), 0);
    frame(16'h8400, 16, got);
    chk("R7 unlock word writes", 32'(cr0_o), 32'h400);
    chk("R8 sleep", 32'(sleep_o), 1);
    frame(16'h8C05, 16, got);
    chk("R7 armed write", 32'(cr0_o), 32'hC05);
    chk("R8 soft reset", 32'(soft_rst_o), 1);
    frame(16'h9777, 16, got);
    chk("R4 cr0 readback", 32'(got), 32'h8400);
    chk("R8 cr1 frozen in reset", 32'(cr1_o), 32'h123);
    frame(16'h8400, 16, got);
    chk("R8 only bit11 in reset", 32'(cr0_o), 32'h405);
    chk("R8 sleep kept", 32'(sleep_o), 1);
    frame(16'h8001, 16, got);
    chk("R7 armed after key", 32'(cr0_o), 32'h001);
    frame(16'h8123, 16, got);
    chk("R4 cr0 old", 32'(got), 32'h8405);
    chk("R7 not armed", 32'(cr0_o), 32'h001);
    frame(16'h8400, 16, got);
    frame(16'h0002, 16, got);
    frame(16'h8000, 16, got);
    chk("R7 audio frame disarms", 32'(cr0_o), 32'h400);
  endtask

  task automatic t_reserved();
    frame(16'hB111, 16, got);
    chk("R11 cr0 unchanged", 32'(cr0_o), 32'h400);
    chk("R11 cr1 unchanged", 32'(cr1_o), 32'h123);
    chk("R11 cr2 unchanged", 32'(cr2_o), 32'h0F0);
    frame(16'hF000, 16, got);
    chk("R11 write readback zero", 32'(got), 32'hB000);
    frame(16'h0000, 16, got);
    chk("R11 read zero", 32'(got), 32'hF000);
  endtask

  task automatic t_hw_reset();
    frame(16'h8400, 16, got);
    frame(16'h8800, 16, got);
    chk("R8 soft reset set", 32'(soft_rst_o), 1);
    do_reset();
    frame(16'h0000, 16, got);
    chk("R1 response cleared", 32'(got), 0);
  endtask

  task automatic t_comp();
    comp_i = 1'b1;
    tx_audio_i = 16'h12AB;
    frame(16'h00C7, 16, got);
    chk("R9 rx companded", 32'(rx_audio_o), 32'h00C7);
    frame(16'h0011, 16, got);
    chk("R9 tx companded", 32'(got), 32'hAB00);
    chk("R9 rx companded 2", 32'(rx_audio_o), 32'h0011);
  endtask

  task automatic t_narrow();
    wide_i = 1'b0;
    tx_audio_i = 16'h0096;
    frame(16'h009F, 8, got);
    chk("R10 byte out", 32'(got), 32'h00AB);
    chk("R10 bit7 is audio", 32'(rx_audio_o), 32'h009F);
    chk("R10 no reg access", 32'(cr0_o), 0);
    frame(16'h0001, 8, got);
    chk("R10 tx byte", 32'(got), 32'h0096);
    chk("R10 rx byte", 32'(rx_audio_o), 32'h0001);
  endtask

  initial begin
    do_reset();
    t_audio();
    t_regs();
    t_cr0();
    t_reserved();
    t_hw_reset();
    t_comp();
    t_narrow();
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule